// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog with a small register file behind a single-cycle read/write strobe. Software sets the mode bits and loads a time-out constant. It then proves it is alive by writing a two-byte feed code to the feed register. A 24-bit down-counter runs on the watchdog clock and steps once every `PRESCALE` clocks. A completed feed reloads the counter from the time-out register. The counter starts only once the enable bit is set and a first feed has completed.

While running, the block raises a level interrupt when the counter passes a warning compare value. It raises a sticky reset request for any of these faults: the counter reaches zero in reset mode, a feed arrives while the counter is still above the window compare value, a feed sequence is broken by any other access, or a protected time-out write comes too early. Every fault also sets a time-out flag that software can read and clear. The current counter value is visible on a port and through the register file.

Top module: `wdog_window`

## Requirements
- R1: Register offsets are 0 control, 1 time-out, 2 feed, 3 counter (read only), 4 warning compare and 5 window compare. After reset, control reads 0, time-out 0xFF, counter 0xFF, warning 0, window 0xFFFFFF, and `wdt_rst` and `wdt_irq` are low.
- R2: A time-out write below 0xFF stores 0xFF. Any other time-out write stores the written value.
- R3: Control bit 0 (enable) alone does not start the counter. A feed (0xAA, then 0x55 as the next access, both written to offset 2) must follow. Until the counter runs, a broken sequence sets no flag and raises no reset.
- R4: While running, the counter drops by one every `PRESCALE` clocks and holds at zero. A completed feed reloads it from the time-out register and restarts the prescale phase.
- R5: While running, if 0xAA is followed by any access other than a write of 0x55 to offset 2, the time-out flag (control bit 2) is set. If reset-enable (control bit 1) is set, `wdt_rst` goes high on the second rising edge after the bad access and stays high until `rst_n`.
- R6: With reset-enable clear, no fault ever raises `wdt_rst`, and the counter rests at zero.
- R7: While running, a counter equal to the warning compare value sets the warning flag (control bit 3), which drives `wdt_irq`. Writing 1 to bit 3 clears it.
- R8: In reset mode, a counter of zero raises `wdt_rst` two edges later and sets the time-out flag.
- R9: A feed that completes while the running counter is above the window value is a fault and does not reload the counter.
- R10: With the protect bit (control bit 4) set, a time-out write while running with counter ≥ warning or counter > window is a fault and is discarded. Otherwise the write is stored.
- R11: Control bits 0, 1 and 4 can only be set; only `rst_n` clears them. Writing 0 to bit 2 clears the time-out flag, and writing 1 to bit 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 3 | Register offset |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr` |
| wdt_rst | output | 1 | Registered, sticky watchdog reset request |
| wdt_irq | output | 1 | Level warning interrupt |
| count | output | 24 | Current counter value |

## Verification
The hardest case to reach is a protected time-out write that lands after the counter has fallen below both compare values. This needs a running counter, a warning value set mid-run, and hundreds of idle cycles before the write is accepted. The bench waits on its own model's counter until it crosses the warning value and then issues the write. It also arms a feed and then breaks it with a read, and checks the reset request in the exact cycle it appears. A behavioural model compares counter, interrupt and reset on every clock.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CW = 24,
  parameter int PRESCALE = 4,
  parameter int TC_MIN = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [2:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          wdt_rst,
  output logic          wdt_irq,
  output logic [CW-1:0] count
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_TC = 3'd1, A_FEED = 3'd2,
                         A_CNT = 3'd3, A_WARN = 3'd4, A_WIN = 3'd5;
  localparam logic [CW-1:0] FLOOR = CW'(TC_MIN);

  logic en, rst_en, prot, tof, wflag, armed, running, pend;
  logic [PW-1:0] pre;
  logic [CW-1:0] tc, warn, win;

  wire acc        = wr_en | rd_en;
  wire feed_wr    = wr_en && addr == A_FEED;
  wire ctrl_wr    = wr_en && addr == A_CTRL;
  wire seq_ok     = armed && feed_wr && wdata == CW'(8'h55);
  wire seq_bad    = armed && acc && !seq_ok;
  wire early      = running && count > win;
  wire feed_fault = seq_ok && early;
  wire do_reload  = seq_ok && !early;
  wire tc_try     = wr_en && addr == A_TC && !armed;
  wire prot_fault = tc_try && running && prot && (count >= warn || count > win);
  wire tc_wr      = tc_try && !prot_fault;
  wire zero_fault = running && rst_en && count == '0;
  wire fault      = (seq_bad && running) || feed_fault || prot_fault || zero_fault;
  wire tick       = running && pre == PW'(PRESCALE - 1);

  assign wdt_irq = wflag;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = CW'({prot, wflag, tof, rst_en, en});
      A_TC:    rdata = tc;
      A_CNT:   rdata = count;
      A_WARN:  rdata = warn;
      A_WIN:   rdata = win;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; rst_en <= 1'b0; prot <= 1'b0;
      tof <= 1'b0; wflag <= 1'b0; armed <= 1'b0;
      running <= 1'b0; pend <= 1'b0; wdt_rst <= 1'b0;
      pre <= '0;
      tc <= FLOOR; count <= FLOOR; warn <= '0; win <= '1;
    end else begin
      pend <= fault;
      if (pend) begin
        tof <= 1'b1;
        if (rst_en) wdt_rst <= 1'b1;
      end else if (ctrl_wr && !wdata[2]) tof <= 1'b0;

      if (running && count == warn) wflag <= 1'b1;
      else if (ctrl_wr && wdata[3]) wflag <= 1'b0;

      if (ctrl_wr) begin
        en     <= en | wdata[0];
        rst_en <= rst_en | wdata[1];
        prot   <= prot | wdata[4];
      end

      armed <= armed ? !acc : (feed_wr && wdata == CW'(8'hAA));

      if (tc_wr) tc <= (wdata < FLOOR) ? FLOOR : wdata;
      if (wr_en && addr == A_WARN) warn <= wdata;
      if (wr_en && addr == A_WIN) win <= wdata;

      if (do_reload) begin
        count <= tc;
        pre <= '0;
        if (en) running <= 1'b1;
      end else if (running) begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick && count != '0) count <= count - 1'b1;
      end
    end
  end

  assert_tc_floor_R2: assert property (@(posedge clk) disable iff (!rst_n) tc >= FLOOR);
  assert_idle_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !do_reload) |=> $stable(count));
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !do_reload) |=> (count == $past(count) || count == $past(count) - 1'b1));
  assert_bad_seq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_bad && running && rst_en) |=> ##1 wdt_rst);
  assert_int_mode_R6: assert property (@(posedge clk) disable iff (!rst_n) !rst_en |-> !wdt_rst);
  assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && rst_en && count == '0) |=> ##1 wdt_rst);
  assert_early_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (feed_fault && rst_en) |=> ##1 wdt_rst);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rst_en) |=> (en && rst_en));
endmodule

// File: tb/wdog_window_test.sv
`timescale 1ns/100ps
module wdog_window_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [23:0] wdata = '0, rdata, count;
  logic wdt_rst, wdt_irq;
  int tests = 0, fails = 0;
  bit done = 0;

  wdog_window uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq), .count(count));

  always #2.5 clk = ~clk;

  // behavioural reference state
  int m_en, m_rsten, m_prot, m_tof, m_wf, m_arm, m_run, m_cnt, m_pre, m_tc, m_warn, m_win, m_pend, m_rst;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_rsten = 0; m_prot = 0; m_tof = 0; m_wf = 0; m_arm = 0; m_run = 0;
      m_cnt = 255; m_pre = 0; m_tc = 255; m_warn = 0; m_win = 'hFFFFFF; m_pend = 0; m_rst = 0;
    end else begin
      bit acc, fd, good, bad, flt, rel, tcw;
      int d;
      d = int'(wdata);
      acc = wr_en || rd_en;
      fd = wr_en && addr == 2;
      good = m_arm != 0 && fd && d == 'h55;
      bad = m_arm != 0 && acc && !good;
      rel = good && !(m_run != 0 && m_cnt > m_win);
      flt = (bad && m_run != 0) || (good && m_run != 0 && m_cnt > m_win) ||
            (m_run != 0 && m_rsten != 0 && m_cnt == 0);
      tcw = wr_en && addr == 1 && m_arm == 0;
      if (tcw && m_run != 0 && m_prot != 0 && (m_cnt >= m_warn || m_cnt > m_win)) begin
        flt = 1; tcw = 0;
      end
      if (m_pend != 0) begin m_tof = 1; if (m_rsten != 0) m_rst = 1; end
      else if (wr_en && addr == 0 && !wdata[2]) m_tof = 0;
      if (m_run != 0 && m_cnt == m_warn) m_wf = 1;
      else if (wr_en && addr == 0 && wdata[3]) m_wf = 0;
      if (rel) begin
        m_cnt = m_tc; m_pre = 0;
        if (m_en != 0) m_run = 1;
      end else if (m_run != 0) begin
        if (m_pre == 3) begin m_pre = 0; if (m_cnt > 0) m_cnt--; end
        else m_pre++;
      end
      if (wr_en && addr == 0) begin
        if (wdata[0]) m_en = 1;
        if (wdata[1]) m_rsten = 1;
        if (wdata[4]) m_prot = 1;
      end
      if (m_arm != 0) m_arm = acc ? 0 : 1;
      else m_arm = (fd && d == 'hAA) ? 1 : 0;
      if (tcw) m_tc = (d < 255) ? 255 : d;
      if (wr_en && addr == 4) m_warn = d;
      if (wr_en && addr == 5) m_win = d;
      m_pend = flt ? 1 : 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 counter vs model", int'(count), m_cnt);
      chk("R7 irq vs model", int'(wdt_irq), m_wf);
      chk("R8 reset request vs model", int'(wdt_rst), m_rst);
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = 24'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); rd_en = 1'b1; addr = a; #1 v = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic feed();
    wr(3'd2, 'hAA); wr(3'd2, 'h55);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    // R1 reset values
    rd(3'd0, v); chk("R1 ctrl reset", v, 0);
    rd(3'd1, v); chk("R1 timeout reset", v, 'hFF);
    rd(3'd3, v); chk("R1 count reset", v, 'hFF);
    rd(3'd4, v); chk("R1 warn reset", v, 0);
    rd(3'd5, v); chk("R1 window reset", v, 'hFFFFFF);
    chk("R1 outputs low", int'({wdt_rst, wdt_irq}), 0);
    // R2 floor
    wr(3'd1, 'h10); rd(3'd1, v); chk("R2 floor", v, 'hFF);
    wr(3'd1, 'h300); rd(3'd1, v); chk("R2 store", v, 'h300);
    // R3 not running before enable+feed
    wr(3'd2, 'hAA); rd(3'd0, v); chk("R3 broken seq ignored", v, 0);
    feed(); idle(20); chk("R3 count held without enable", int'(count), 'h300);
    wr(3'd0, 1); idle(20); chk("R3 enable alone holds", int'(count), 'h300);
    feed(); idle(40); chk("R4 counting", int'(count < 24'h300), 1);
    // R7 warning
    wr(3'd4, m_cnt - 3); idle(30); chk("R7 irq raised", int'(wdt_irq), 1);
    wr(3'd0, 'h8); chk("R7 irq cleared", int'(wdt_irq), 0);
    // R5/R6 broken sequence in interrupt-only mode
    wr(3'd2, 'hAA); rd(3'd0, v); idle(3);
    rd(3'd0, v); chk("R5 tof set", (v >> 2) & 1, 1);
    chk("R6 no reset in int mode", int'(wdt_rst), 0);
    wr(3'd0, 0); rd(3'd0, v);
    chk("R11 tof cleared", (v >> 2) & 1, 0);
    chk("R11 enable sticky", v & 1, 1);
    wr(3'd0, 'h4); rd(3'd0, v); chk("R11 write 1 to tof no effect", (v >> 2) & 1, 0);
    // R9 early feed
    wr(3'd5, 'h10); v = int'(count); feed(); idle(3);
    chk("R9 no reload", int'(count <= 24'(v)), 1);
    rd(3'd0, v); chk("R9 tof set", (v >> 2) & 1, 1);
    // R10 protect
    do_reset();
    wr(3'd1, 'h100); wr(3'd0, 'h11); feed(); wr(3'd4, 'h80);
    wr(3'd1, 'h200); rd(3'd1, v); chk("R10 early write discarded", v, 'h100);
    rd(3'd0, v); chk("R10 fault sets tof", (v >> 2) & 1, 1);
    wr(3'd0, 0);
    while (m_cnt >= 'h80) @(negedge clk);
    wr(3'd1, 'h200); rd(3'd1, v); chk("R10 late write stored", v, 'h200);
    rd(3'd0, v); chk("R10 late write no fault", (v >> 2) & 1, 0);
    // R5 reset timing in reset mode
    do_reset();
    wr(3'd0, 'h3); feed(); idle(5);
    wr(3'd2, 'hAA); rd(3'd3, v);
    chk("R5 not yet after first edge", int'(wdt_rst), 0);
    @(negedge clk); chk("R5 reset on second edge", int'(wdt_rst), 1);
    idle(5); chk("R5 reset sticky", int'(wdt_rst), 1);
    // R8 time-out to zero
    do_reset();
    wr(3'd0, 'h3); feed(); idle(1100);
    chk("R8 reset at zero", int'(wdt_rst), 1);
    rd(3'd0, v); chk("R8 tof set", (v >> 2) & 1, 1);
    // R6 interrupt-only rests at zero
    do_reset();
    wr(3'd0, 'h1); feed(); idle(1100);
    chk("R6 count rests at zero", int'(count), 0);
    chk("R6 no reset", int'(wdt_rst), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule